// File: doc/BRIEF.md
# Byte Parity Check and Generate Unit

This unit sits on one 36-bit data port that carries four 9-bit bytes. Each byte holds eight data bits and a parity bit in its top position. On the input side the unit checks every byte of the incoming bus against the selected parity sense. Only the bytes marked valid by the current bus width are checked. The result goes out on a registered, active-low error flag.

On the read side the unit loads an output register from one of two sources: the FIFO storage word or the mailbox word. When generation is enabled, the top bit of each byte is replaced with parity computed from that byte's lower eight bits. The source words are never modified.

The four parity trees that check the input bus are also used to generate parity for mailbox reads. While a mailbox read with generation is in progress, checking is suspended and the error flag is held inactive. FIFO reads have their own generation trees, placed between the storage data and the output register.

Top module: `byte_parity_port`

## Requirements
- R1: After reset, `parErrN` is 1 and `rdData` is all zeros.
- R2: Odd mode (`oddSel`=1) counts a byte as correct when its nine bits hold an odd number of ones. `parErrN` goes to 0 on the clock after any valid byte of `busIn` fails this rule.
- R3: Even mode (`oddSel`=0) counts a byte as correct when its nine bits hold an even number of ones. Failures are flagged on `parErrN` with the same one-clock latency as in R2.
- R4: A byte takes part in checking only when its `byteValid` bit is set. Bit k of `byteValid` covers byte k, which occupies bits 9k+8 down to 9k. A failing byte whose valid bit is clear leaves `parErrN` at 1.
- R5: `parErrN` reflects only the bus sampled on the previous edge. It returns to 1 on the clock after a correct bus is presented.
- R6: A mailbox read with generation is the condition `csN`=0, `en`=1, `wrRd`=0, `mbxSel`=1 and `genEn`=1. During such a read, `parErrN` is 1 on the next clock whatever `busIn` carries.
- R7: A read is the condition `csN`=0, `en`=1 and `wrRd`=0. On a read with `genEn`=1, each output byte keeps its low eight bits from the source. Its bit 8 becomes parity over those eight bits: in odd mode it makes the nine-bit ones count odd, and in even mode it makes that count even.
- R8: On a read with `genEn`=0, all 36 bits of the selected source appear unchanged on `rdData`, including every parity bit.
- R9: `rdData` changes only on the clock edge of a read. Changes to `genEn`, `oddSel` or the source data between reads leave it unchanged.
- R10: A read with `mbxSel`=1 loads from `mbxData`. A read with `mbxSel`=0 loads from `fifoData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| oddSel | input | 1 | 1 selects odd parity, 0 selects even parity |
| genEn | input | 1 | Enables parity generation on reads |
| byteValid | input | 4 | Per-byte enable for input checking |
| csN | input | 1 | Active-low port select |
| en | input | 1 | Access enable |
| wrRd | input | 1 | 1 for a write, 0 for a read |
| mbxSel | input | 1 | Selects the mailbox word as read source |
| busIn | input | 36 | Incoming port bus to be checked |
| fifoData | input | 36 | Word from FIFO storage |
| mbxData | input | 36 | Word from the mailbox register |
| parErrN | output | 1 | Registered active-low parity error flag |
| rdData | output | 36 | Registered read word |

## Verification
The assertions assume the control inputs are at defined levels on every clock edge, and that the source words hold steady around the edge of a read. The bench changes all inputs only on the falling edge, so every rising edge samples settled values. Mailbox reads with generation are applied while `busIn` carries deliberately bad bytes, which exercises the forced-inactive flag. Ignored bytes are corrupted with their mask bit clear, and the flag is watched on the following clock.

// File: rtl/byte_parity_pkg.sv
package byte_parity_pkg;
  localparam int NUM_BYTES = 4;
  localparam int BYTE_BITS = 9;
  localparam int BUS_W     = NUM_BYTES * BYTE_BITS;

  typedef struct packed {
    logic readLoad;   // output register loads this edge
    logic useMbx;     // mailbox is the read source
    logic genApply;   // substitute generated parity
    logic oddMode;    // parity sense
    logic holdOk;     // shared trees busy with mailbox, flag forced high
  } strobe_t;
endpackage

// File: rtl/parity_trees.sv
module parity_trees #(
  parameter int NUM_BYTES = 4,
  parameter int BYTE_BITS = 9,
  localparam int BUS_W = NUM_BYTES * BYTE_BITS
) (
  input  logic [BUS_W-1:0]     data,
  input  logic                 oddMode,
  output logic [NUM_BYTES-1:0] fail,
  output logic [NUM_BYTES-1:0] genBit
);
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_tree
    logic fullXor;
    logic lowXor;
    assign fullXor   = ^data[b*BYTE_BITS +: BYTE_BITS];
    assign lowXor    = ^data[b*BYTE_BITS +: BYTE_BITS-1];
    assign fail[b]   = oddMode ? ~fullXor : fullXor;
    assign genBit[b] = oddMode ? ~lowXor : lowXor;
  end
endmodule

// File: rtl/parity_ctrl.sv
module parity_ctrl
  import byte_parity_pkg::*;
(
  input  logic    oddSel,
  input  logic    genEn,
  input  logic    csN,
  input  logic    en,
  input  logic    wrRd,
  input  logic    mbxSel,
  output strobe_t strobes
);
  logic readAccess;
  assign readAccess = ~csN & en & ~wrRd;

  always_comb begin
    strobes.readLoad = readAccess;
    strobes.useMbx   = mbxSel;
    strobes.genApply = genEn;
    strobes.oddMode  = oddSel;
    strobes.holdOk   = readAccess & mbxSel & genEn;
  end
endmodule

// File: rtl/parity_datapath.sv
module parity_datapath
  import byte_parity_pkg::*;
#(
  parameter int NUM_BYTES = 4,
  parameter int BYTE_BITS = 9,
  localparam int BUS_W = NUM_BYTES * BYTE_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [NUM_BYTES-1:0] byteValid,
  input  logic [BUS_W-1:0]     busIn,
  input  logic [BUS_W-1:0]     fifoData,
  input  logic [BUS_W-1:0]     mbxData,
  output logic                 parErrN,
  output logic [BUS_W-1:0]     rdData
);
  logic [BUS_W-1:0]     sharedIn;
  logic [NUM_BYTES-1:0] sharedFail;
  logic [NUM_BYTES-1:0] sharedGen;
  logic [NUM_BYTES-1:0] fifoFail;
  logic [NUM_BYTES-1:0] fifoGen;
  logic [BUS_W-1:0]     mbxOut;
  logic [BUS_W-1:0]     fifoOut;
  logic [BUS_W-1:0]     nextRd;

  // Shared trees: check the bus, or generate for a mailbox read
  assign sharedIn = strobes.holdOk ? mbxData : busIn;

  parity_trees #(.NUM_BYTES(NUM_BYTES), .BYTE_BITS(BYTE_BITS)) u_shared (
    .data(sharedIn), .oddMode(strobes.oddMode),
    .fail(sharedFail), .genBit(sharedGen)
  );

  // Dedicated trees between storage and the output register
  parity_trees #(.NUM_BYTES(NUM_BYTES), .BYTE_BITS(BYTE_BITS)) u_fifo (
    .data(fifoData), .oddMode(strobes.oddMode),
    .fail(fifoFail), .genBit(fifoGen)
  );

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_sub
    localparam int TOP = b*BYTE_BITS + BYTE_BITS - 1;
    assign mbxOut[TOP-1 -: BYTE_BITS-1]  = mbxData[TOP-1 -: BYTE_BITS-1];
    assign mbxOut[TOP]                   = strobes.genApply ? sharedGen[b] : mbxData[TOP];
    assign fifoOut[TOP-1 -: BYTE_BITS-1] = fifoData[TOP-1 -: BYTE_BITS-1];
    assign fifoOut[TOP]                  = strobes.genApply ? fifoGen[b] : fifoData[TOP];
  end

  assign nextRd = strobes.useMbx ? mbxOut : fifoOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parErrN <= 1'b1;
      rdData  <= '0;
    end else begin
      parErrN <= strobes.holdOk ? 1'b1 : ~|(sharedFail & byteValid);
      if (strobes.readLoad) rdData <= nextRd;
    end
  end

  logic unusedFifoFail;
  assign unusedFifoFail = ^fifoFail;
endmodule

// File: rtl/byte_parity_port.sv
module byte_parity_port
  import byte_parity_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 oddSel,
  input  logic                 genEn,
  input  logic [NUM_BYTES-1:0] byteValid,
  input  logic                 csN,
  input  logic                 en,
  input  logic                 wrRd,
  input  logic                 mbxSel,
  input  logic [BUS_W-1:0]     busIn,
  input  logic [BUS_W-1:0]     fifoData,
  input  logic [BUS_W-1:0]     mbxData,
  output logic                 parErrN,
  output logic [BUS_W-1:0]     rdData
);
  strobe_t strobes;

  parity_ctrl u_ctrl (
    .oddSel(oddSel), .genEn(genEn), .csN(csN), .en(en),
    .wrRd(wrRd), .mbxSel(mbxSel), .strobes(strobes)
  );

  parity_datapath #(.NUM_BYTES(NUM_BYTES), .BYTE_BITS(BYTE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteValid(byteValid),
    .busIn(busIn), .fifoData(fifoData), .mbxData(mbxData),
    .parErrN(parErrN), .rdData(rdData)
  );
endmodule

// File: rtl/byte_parity_port_chk.sv
module byte_parity_port_chk
  import byte_parity_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 oddSel,
  input logic                 genEn,
  input logic [NUM_BYTES-1:0] byteValid,
  input logic                 csN,
  input logic                 en,
  input logic                 wrRd,
  input logic                 mbxSel,
  input logic [BUS_W-1:0]     fifoData,
  input logic [BUS_W-1:0]     mbxData,
  input logic                 parErrN,
  input logic [BUS_W-1:0]     rdData
);
  logic isRead;
  assign isRead = !csN && en && !wrRd;

  // R6
  mbx_gen_flag_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && mbxSel && genEn) |=> parErrN);

  // R4
  no_valid_no_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid == '0) |=> parErrN);

  // R9
  hold_between_reads_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> $stable(rdData));

  // R8
  mbx_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && mbxSel && !genEn) |=> rdData == $past(mbxData));

  // R7
  fifo_gen_low_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && !mbxSel && genEn) |=> rdData[7:0] == $past(fifoData[7:0]));

  // R7
  fifo_gen_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && !mbxSel && genEn) |=>
      ($countones(rdData[8:0]) % 2) == ($past(oddSel) ? 1 : 0));
endmodule

bind byte_parity_port byte_parity_port_chk u_chk (
  .clk(clk), .rstN(rstN), .oddSel(oddSel), .genEn(genEn), .byteValid(byteValid),
  .csN(csN), .en(en), .wrRd(wrRd), .mbxSel(mbxSel), .fifoData(fifoData),
  .mbxData(mbxData), .parErrN(parErrN), .rdData(rdData)
);

// File: tb/byte_parity_port_tb.sv
module byte_parity_port_tb;
  logic clk = 0;
  logic rstN, oddSel, genEn, csN, en, wrRd, mbxSel;
  logic [3:0]  byteValid;
  logic [35:0] busIn, fifoData, mbxData;
  logic        parErrN;
  logic [35:0] rdData;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  byte_parity_port u_dut (
    .clk(clk), .rstN(rstN), .oddSel(oddSel), .genEn(genEn), .byteValid(byteValid),
    .csN(csN), .en(en), .wrRd(wrRd), .mbxSel(mbxSel), .busIn(busIn),
    .fifoData(fifoData), .mbxData(mbxData), .parErrN(parErrN), .rdData(rdData)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Byte with chosen low bits; good selects whether it meets the rule in the given mode
  function automatic logic [8:0] mkByte(input logic [7:0] lo, input bit good, input bit odd);
    bit target = odd ^ !good;
    return {target ^ ($countones(lo) % 2 == 1), lo};
  endfunction

  function automatic logic [35:0] genExp(input logic [35:0] w, input bit odd);
    logic [35:0] r = w;
    for (int b = 0; b < 4; b++) begin
      int c = $countones(w[b*9 +: 8]);
      r[b*9+8] = odd ? (c % 2 == 0) : (c % 2 == 1);
    end
    return r;
  endfunction

  function automatic logic [35:0] mkWord(input logic [31:0] lo, input logic [3:0] good, input bit odd);
    logic [35:0] r;
    for (int b = 0; b < 4; b++) r[b*9 +: 9] = mkByte(lo[b*8 +: 8], good[b], odd);
    return r;
  endfunction

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    csN = 1; en = 0; wrRd = 1; mbxSel = 0;
  endtask

  task automatic doRead(input bit mbx);
    csN = 0; en = 1; wrRd = 0; mbxSel = mbx;
    cyc();
    idle();
  endtask

  task automatic test_reset();
    rstN = 0; idle(); oddSel = 1; genEn = 0; byteValid = 4'hF;
    busIn = mkWord(32'h0, 4'h0, 1); fifoData = '1; mbxData = '1;
    cyc(); cyc();
    check("R1 parErrN", {35'd0, parErrN}, 36'd1);
    check("R1 rdData", rdData, 36'd0);
    rstN = 1;
  endtask

  task automatic test_odd_check();
    oddSel = 1; byteValid = 4'hF;
    busIn = mkWord(32'hA5C3_1E77, 4'hF, 1); cyc();
    check("R2 odd all good", {35'd0, parErrN}, 36'd1);
    busIn = mkWord(32'hA5C3_1E77, 4'b1011, 1); cyc();
    check("R2 odd byte2 bad", {35'd0, parErrN}, 36'd0);
    busIn = mkWord(32'hA5C3_1E77, 4'hF, 1); cyc();
    check("R5 recovers", {35'd0, parErrN}, 36'd1);
  endtask

  task automatic test_even_check();
    oddSel = 0; byteValid = 4'hF;
    busIn = mkWord(32'h0F0F_3355, 4'hF, 0); cyc();
    check("R3 even all good", {35'd0, parErrN}, 36'd1);
    busIn = mkWord(32'h0F0F_3355, 4'b1110, 0); cyc();
    check("R3 even byte0 bad", {35'd0, parErrN}, 36'd0);
    // latency: error appears only after the edge
    busIn = mkWord(32'h0F0F_3355, 4'hF, 0); @(posedge clk); #1;
    check("R5 one-clock latency", {35'd0, parErrN}, 36'd1);
    busIn = mkWord(32'h0F0F_3355, 4'b0111, 0); #1;
    check("R5 no comb path", {35'd0, parErrN}, 36'd1);
    @(negedge clk); cyc();
    check("R3 byte3 bad", {35'd0, parErrN}, 36'd0);
  endtask

  task automatic test_mask();
    oddSel = 1;
    busIn = mkWord(32'h1234_5678, 4'b0101, 1); byteValid = 4'b0101; cyc();
    check("R4 masked bad bytes ignored", {35'd0, parErrN}, 36'd1);
    byteValid = 4'b0111; cyc();
    check("R4 byte1 valid and bad", {35'd0, parErrN}, 36'd0);
    byteValid = 4'b0000; busIn = mkWord(32'h0, 4'h0, 1); cyc();
    check("R4 no valid bytes", {35'd0, parErrN}, 36'd1);
    byteValid = 4'hF;
  endtask

  task automatic test_mbx_force();
    oddSel = 1; genEn = 1; byteValid = 4'hF;
    busIn = mkWord(32'hDEAD_BEEF, 4'h0, 1);
    mbxData = {1'b0, 8'h81, 1'b1, 8'h7F, 1'b0, 8'h00, 1'b1, 8'hFE};
    doRead(1);
    check("R6 flag held high", {35'd0, parErrN}, 36'd1);
    check("R7 mbx gen odd", rdData, genExp(mbxData, 1));
    cyc();
    check("R6 checking resumes", {35'd0, parErrN}, 36'd0);
    genEn = 0; csN = 0; en = 1; wrRd = 0; mbxSel = 1; cyc(); idle();
    check("R6 no gen: checking active", {35'd0, parErrN}, 36'd0);
    busIn = mkWord(32'h0, 4'hF, 1);
  endtask

  task automatic test_gen_fifo();
    genEn = 1;
    fifoData = {9'h1AB, 9'h055, 9'h100, 9'h0FF};
    oddSel = 1; doRead(0);
    check("R7 fifo gen odd", rdData, genExp(fifoData, 1));
    oddSel = 0; doRead(0);
    check("R7 fifo gen even", rdData, genExp(fifoData, 0));
  endtask

  task automatic test_passthru();
    genEn = 0; oddSel = 1;
    fifoData = 36'h9_8765_4321; mbxData = 36'h1_2345_6789;
    doRead(0);
    check("R8 fifo unchanged", rdData, 36'h9_8765_4321);
    check("R10 fifo source", rdData, fifoData);
    doRead(1);
    check("R8 mbx unchanged", rdData, 36'h1_2345_6789);
    check("R10 mbx source", rdData, mbxData);
  endtask

  task automatic test_hold();
    logic [35:0] held;
    held = rdData;
    genEn = 1; oddSel = 0; fifoData = 36'hF_0000_0000; mbxData = 36'h0_FFFF_FFFF;
    cyc(); cyc();
    check("R9 hold while idle", rdData, held);
    csN = 0; en = 1; wrRd = 1; mbxSel = 0; cyc(); idle();
    check("R9 hold on write", rdData, held);
    csN = 1; en = 1; wrRd = 0; cyc(); idle();
    check("R9 hold when deselected", rdData, held);
    doRead(0);
    check("R9 loads on read", rdData, genExp(36'hF_0000_0000, 0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_odd_check();
    test_even_check();
    test_mask();
    test_mbx_force();
    test_gen_fifo();
    test_passthru();
    test_hold();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule